// File: doc/BRIEF.md
# Round-Robin Multi-Channel ADC Acquisition Sequencer

This block runs a multiplexed 8-bit analog-to-digital converter without pause and keeps the most recent sample of every input in its own holding register. A channel counter drives the converter's address lines. A Mealy controller issues a start-conversion pulse and waits for the end-of-conversion handshake. When the conversion finishes, the controller enables the converter output and steers the byte through a decoder, gated by the capture enable, into the register of the current channel. The channel counter then advances. After the last input it returns to input 0, and the cycle repeats for as long as the block is running.

One control cycle passes through six steps: start, wait for end-of-conversion to fall, wait for it to rise, read, store, and increment. The default build serves four inputs with a 2-bit counter. Setting the channel-count parameter to eight widens the counter to 3 bits and the decoder to eight outputs. Each time a register is written, the block also gives a one-cycle write strobe together with the index of the channel that was written.

Top module: `acq_rr_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after reset, all result words are zero, the write strobe is low and the address is 0. The controller is in its start step, so `conv_start` is high.
- R2: `conv_start` is high for exactly one cycle per conversion. The controller then enters the first wait step, where `conv_start` and `rd_en` are both low.
- R3: In the first wait step the controller stays put while `eoc` is high, and `rd_en` stays low. It leaves that step on the first clock edge at which `eoc` is low.
- R4: In the second wait step the controller stays put while `eoc` is low, with `rd_en` low and no register write.
- R5: In the second wait step, `eoc` high raises `rd_en` combinationally in the same cycle. On that clock edge, `adc_data` is stored into the result word of the current channel.
- R6: `rd_en` stays high for one further cycle (the read step) and is low in the store step that follows.
- R7: Only the result word of the current channel changes on a capture. No word changes outside a capture, whatever `adc_data` does.
- R8: After the store step the address rises by one. From NUM_CH-1 it returns to 0, and the new address is present from the increment step onward.
- R9: The address stays constant from the start step through the store step of each conversion.
- R10: In the cycle after each capture, `wr_valid` is high for one cycle and `wr_chan` gives the index of the channel that was written.
- R11: Result word k occupies bits [8k+7:8k] of `results`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoc | input | 1 | End-of-conversion from the converter, high when idle or done |
| adc_data | input | DATA_W | Converted byte from the converter |
| adc_addr | output | CH_W | Analog channel select |
| conv_start | output | 1 | Address-latch / start-conversion pulse |
| rd_en | output | 1 | Converter output enable |
| results | output | NUM_CH*DATA_W | Holding registers, word k at bits [8k+7:8k] |
| wr_valid | output | 1 | One-cycle strobe after a register write |
| wr_chan | output | CH_W | Index of the register just written |

## Verification
The assertions assume a well-behaved converter. It drops `eoc` some time after a start pulse and raises it again only once the data is ready. `adc_data` is valid on the edge at which `eoc` is seen high in the second wait step. The stimulus models exactly that handshake. It waits a varying number of cycles with `eoc` high and then with `eoc` low, and presents the byte together with the rising `eoc`. It then scrambles `adc_data` straight away, so that any capture outside the handshake would show up in the result words.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [2:0] {
        ST_START,
        ST_WAIT1,
        ST_WAIT2,
        ST_READ,
        ST_STORE,
        ST_INCR
    } acq_state_e;

    typedef struct packed {
        logic sc;
        logic oe;
        logic cnt_en;
        logic latch_en;
    } acq_ctl_t;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
    import acq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     eoc,
    output acq_ctl_t ctl
);
    typedef struct packed {
        acq_state_e state;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;
    acq_ctl_t  ctl_d;

    always_comb begin
        r_d   = r_q;
        ctl_d = '0;
        unique case (r_q.state)
            ST_START: begin
                ctl_d.sc  = 1'b1;
                r_d.state = ST_WAIT1;
            end
            ST_WAIT1: begin
                if (!eoc) r_d.state = ST_WAIT2;
            end
            ST_WAIT2: begin
                if (eoc) begin
                    ctl_d.oe       = 1'b1;
                    ctl_d.latch_en = 1'b1;
                    r_d.state      = ST_READ;
                end
            end
            ST_READ: begin
                ctl_d.oe  = 1'b1;
                r_d.state = ST_STORE;
            end
            ST_STORE: begin
                ctl_d.cnt_en = 1'b1;
                r_d.state    = ST_INCR;
            end
            ST_INCR: r_d.state = ST_START;
            default: r_d.state = ST_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: ST_START};
        else        r_q <= r_d;
    end

    assign ctl = ctl_d;

    p_sc_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sc |=> !ctl.sc && !ctl.oe);
    p_oe_two_cycles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.latch_en |=> ctl.oe ##1 !ctl.oe);
    p_wait1_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT1 && eoc) |-> !ctl.oe);
endmodule

// File: rtl/acq_chan_cnt.sv
module acq_chan_cnt #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnt_en,
    output logic [CH_W-1:0] chan
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

    logic [CH_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_en) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign chan = cnt_q;

    p_step_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> chan == (($past(chan) == LAST) ? '0 : CH_W'($past(chan) + 1'b1)));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(chan));
endmodule

// File: rtl/acq_bank.sv
module acq_bank #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     latch_en,
    input  logic [CH_W-1:0]          chan,
    input  logic [DATA_W-1:0]        din,
    output logic [NUM_CH*DATA_W-1:0] results,
    output logic                     wr_valid,
    output logic [CH_W-1:0]          wr_chan
);
    typedef struct packed {
        logic [NUM_CH*DATA_W-1:0] words;
        logic                     valid;
        logic [CH_W-1:0]          chan;
    } bank_reg_t;

    logic [NUM_CH-1:0] sel;
    bank_reg_t         r_d, r_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign sel[g] = latch_en && (chan == CH_W'(g));
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = latch_en;
        if (latch_en) r_d.chan = chan;
        for (int k = 0; k < NUM_CH; k++) begin
            if (sel[k]) r_d.words[k*DATA_W +: DATA_W] = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign results  = r_q.words;
    assign wr_valid = r_q.valid;
    assign wr_chan  = r_q.chan;

    p_onehot_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel) && (latch_en == (sel != '0)));
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(results));
    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
endmodule

// File: rtl/acq_rr_sequencer.sv
module acq_rr_sequencer
    import acq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     eoc,
    input  logic [DATA_W-1:0]        adc_data,
    output logic [CH_W-1:0]          adc_addr,
    output logic                     conv_start,
    output logic                     rd_en,
    output logic [NUM_CH*DATA_W-1:0] results,
    output logic                     wr_valid,
    output logic [CH_W-1:0]          wr_chan
);
    acq_ctl_t        ctl;
    logic [CH_W-1:0] chan;

    acq_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .eoc   (eoc),
        .ctl   (ctl)
    );

    acq_chan_cnt #(.NUM_CH(NUM_CH)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (ctl.cnt_en),
        .chan   (chan)
    );

    acq_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (ctl.latch_en),
        .chan     (chan),
        .din      (adc_data),
        .results  (results),
        .wr_valid (wr_valid),
        .wr_chan  (wr_chan)
    );

    assign adc_addr   = chan;
    assign conv_start = ctl.sc;
    assign rd_en      = ctl.oe;

    p_capture_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.latch_en |-> rd_en && eoc);
    p_chan_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.latch_en |=> wr_valid && wr_chan == $past(adc_addr));
    p_addr_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> $stable(adc_addr));
endmodule

// File: tb/acq_rr_sequencer_bench.sv
module acq_rr_sequencer_bench;
    localparam int CLK_P  = 10;
    localparam int NUM_CH = 4;
    localparam int DATA_W = 8;
    localparam int CH_W   = $clog2(NUM_CH);

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     eoc = 1'b1;
    logic [DATA_W-1:0]        adc_data = '0;
    logic [CH_W-1:0]          adc_addr;
    logic                     conv_start, rd_en, wr_valid;
    logic [NUM_CH*DATA_W-1:0] results;
    logic [CH_W-1:0]          wr_chan;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [DATA_W-1:0] exp_res [NUM_CH];
    int  exp_ch = 0;

    always #(CLK_P/2) clk = ~clk;

    acq_rr_sequencer #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_acq_rr_sequencer (
        .clk(clk), .rst_n(rst_n), .eoc(eoc), .adc_data(adc_data),
        .adc_addr(adc_addr), .conv_start(conv_start), .rd_en(rd_en),
        .results(results), .wr_valid(wr_valid), .wr_chan(wr_chan)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_words(input string req);
        for (int k = 0; k < NUM_CH; k++)
            chk(results[k*DATA_W +: DATA_W] == exp_res[k], req, "result word",
                results[k*DATA_W +: DATA_W], exp_res[k]);
    endtask

    // Called at a negedge while in the start step.
    task automatic convert(input int hold1, input int hold2, input logic [DATA_W-1:0] val);
        int nxt;
        nxt = (exp_ch + 1) % NUM_CH;
        chk(conv_start == 1'b1, "R2", "start pulse", conv_start, 1);
        chk(adc_addr == CH_W'(exp_ch), "R8", "address at start", adc_addr, exp_ch);
        @(negedge clk);
        chk(conv_start == 1'b0 && rd_en == 1'b0, "R2", "start single", {conv_start, rd_en}, 0);
        for (int i = 0; i < hold1; i++) begin
            @(negedge clk);
            chk(rd_en == 1'b0, "R3", "wait1 with eoc high", rd_en, 0);
            chk(adc_addr == CH_W'(exp_ch), "R9", "address wait1", adc_addr, exp_ch);
        end
        eoc = 1'b0;
        for (int i = 0; i <= hold2; i++) begin
            @(negedge clk);
            chk(rd_en == 1'b0 && wr_valid == 1'b0, "R4", "wait2 idle", {rd_en, wr_valid}, 0);
        end
        chk_words("R4");
        eoc = 1'b1;
        adc_data = val;
        #1;
        chk(rd_en == 1'b1, "R5", "oe on eoc rise", rd_en, 1);
        @(negedge clk);
        exp_res[exp_ch] = val;
        adc_data = ~val;
        chk(rd_en == 1'b1, "R6", "oe in read", rd_en, 1);
        chk(wr_valid == 1'b1, "R10", "write strobe", wr_valid, 1);
        chk(wr_chan == CH_W'(exp_ch), "R10", "write channel", wr_chan, exp_ch);
        chk_words("R5");
        @(negedge clk);
        chk(rd_en == 1'b0, "R6", "oe low in store", rd_en, 0);
        chk(wr_valid == 1'b0, "R10", "strobe one cycle", wr_valid, 0);
        chk(adc_addr == CH_W'(exp_ch), "R9", "address in store", adc_addr, exp_ch);
        chk_words("R7");
        @(negedge clk);
        chk(adc_addr == CH_W'(nxt), "R8", "address advanced", adc_addr, nxt);
        chk(conv_start == 1'b0, "R2", "no start in incr", conv_start, 0);
        chk_words("R7");
        @(negedge clk);
        exp_ch = nxt;
    endtask

    initial begin
        for (int k = 0; k < NUM_CH; k++) exp_res[k] = '0;
        repeat (3) @(negedge clk);
        chk(results == '0 && wr_valid == 1'b0, "R1", "in reset", results, 0);
        rst_n = 1'b1;
        #1;
        chk(conv_start == 1'b1, "R1", "start after reset", conv_start, 1);
        chk(adc_addr == '0, "R1", "address after reset", adc_addr, 0);
        chk_words("R1");
        for (int i = 0; i < 3 * NUM_CH + 2; i++) begin
            logic [DATA_W-1:0] v;
            v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : DATA_W'(i * 37 + 5);
            convert(i % 3, i % 4, v);
        end
        // R11: word k sits at bits [8k+7:8k]
        for (int k = 0; k < NUM_CH; k++)
            chk(results[k*8 +: 8] == exp_res[k], "R11", "word position", results[k*8 +: 8], exp_res[k]);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule